// File: doc/BRIEF.md
# Page-Update Emulated EEPROM Controller

This controller gives a host a 1 KB byte-addressed non-volatile store that behaves like an EEPROM. The data actually lives in a flash region of two sectors. Each sector is split into four blocks of 1 KB, so there are eight block locations. A per-sector block pointer and an active-sector flag select the one block that holds the live image. Every host read is translated through that pointer onto a flash word read.

Flash cannot be rewritten in place. For that reason, a host write that covers consecutive bytes inside one 16-byte page is never applied to the live block. The controller instead copies the whole image, word by word, into the next block. While copying, it merges the new page bytes into the stream and skips words that are still in the erased all-ones state. Only when the last word is in place does it switch the pointer, in one clock edge. After block 3 of a sector, the image moves to block 0 of the other sector.

While a copy runs, the controller erases one stale block of the sector that is not the copy source. This keeps a supply of erased blocks ready for later copies. Host reads are served at any time and take priority over the copy engine's reads. Until the switch they return the old image.

Top module: `eee_ctrl`

## Requirements
- R1: After reset `busy`, `done` and `err` are low, and the live image is sector 0 block 0. Flash word addresses are laid out as {sector (1 bit), block (2 bits), word in block (8 bits)}. A host byte address maps to word address bits [9:2], and byte lane bits [1:0] sit at data bits [8*lane+7:8*lane].
- R2: A host read issued with `hr_en` drives `fl_rd_en` in the same cycle, using the translated address of the live block. `hr_valid` rises in the next cycle, and `hr_data` then carries the addressed byte of the live image. An erased, never-written byte reads as 0xFF.
- R3: A write is accepted when the controller is idle, `wr_len` is between 1 and 16, and offset `wr_addr[3:0]` plus `wr_len` is at most 16. Page bytes offset to offset+len-1 then take `wr_data` bytes 0 to len-1, with byte j at bits [8j+7:8j]. Every other byte of the image keeps its value. `busy` is high in the cycle after acceptance.
- R4: A write with length 0, a write that runs past the page end, or a write issued while `busy` is high is rejected. `err` pulses for one cycle in the next cycle, and the image is left unchanged.
- R5: Each accepted write moves the live image to the next block of the same sector. From block 3 it moves to block 0 of the other sector.
- R6: Host reads issued while `busy` is high return the old image, from the old block. Reads issued after `done` return the new image.
- R7: `done` is a one-cycle pulse in the cycle where `busy` falls. The pointer switch takes effect at that same edge.
- R8: No program command carries an all-ones word. No program command is issued to a sector whose `fl_busy` bit is high, or to the live block. The target block is erased before it is programmed, so the copied image is exact.
- R9: Each update issues at most one erase command. That erase goes to the destination block if it is stale, and otherwise to the lowest stale block of the sector that is not the copy source. An erase never goes to the live block, and is never issued in the same cycle as a program.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hr_en | input | 1 | Host byte read request |
| hr_addr | input | 10 | Host read byte address |
| hr_valid | output | 1 | Read data valid, one cycle after the request |
| hr_data | output | 8 | Read byte |
| wr_en | input | 1 | Page write request |
| wr_addr | input | 10 | Write byte address; bits [3:0] are the start offset |
| wr_len | input | 5 | Number of bytes to write, 1 to 16 |
| wr_data | input | 128 | Write bytes, byte j at bits [8j+7:8j] |
| busy | output | 1 | Update in progress |
| done | output | 1 | Update committed (one-cycle pulse) |
| err | output | 1 | Write rejected (one-cycle pulse) |
| fl_rd_en | output | 1 | Flash word read, data next cycle |
| fl_rd_addr | output | 11 | Flash read word address |
| fl_rd_data | input | 32 | Flash read data |
| fl_pg_en | output | 1 | Flash program-word command |
| fl_pg_addr | output | 11 | Flash program word address |
| fl_pg_data | output | 32 | Flash program data |
| fl_er_en | output | 1 | Flash erase-block command |
| fl_er_blk | output | 3 | Erase target {sector, block} |
| fl_busy | input | 2 | Per-sector flash busy |

## Verification
The stimulus includes full-page writes, single-byte writes at the first and last page offset, and short runs at mid-page offsets. Together these separate a wrong merge mask or a wrong byte shift from a wrong word-in-page selection. Seeded random page writes then drive the image through several sector wraps. Any missed or misplaced erase shows up as corrupted data, because the flash model ANDs programmed words. Reads issued during a copy tell a premature pointer switch apart from a correct one. Zero-length, overrunning and busy-time writes are checked for both an error pulse and an untouched image.

// File: rtl/eee_pkg.sv
package eee_pkg;
   typedef enum logic [2:0] {
      EE_IDLE,
      EE_ERASE,
      EE_FETCH,
      EE_MERGE,
      EE_PROG,
      EE_COMMIT
   } ee_state_e;
endpackage

// File: rtl/eee_ptr_bank.sv
// Block pointer per sector plus the active-sector flag; switched in one edge.
module eee_ptr_bank #(
   parameter int BLK_W = 2
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             commit,
   input  logic             new_sec,
   input  logic [BLK_W-1:0] new_blk,
   output logic             live_sec,
   output logic [BLK_W-1:0] live_blk,
   output logic             next_sec,
   output logic [BLK_W-1:0] next_blk
);
   localparam int NB = 1 << BLK_W;

   logic             act_q;
   logic [BLK_W-1:0] ptr_w [2];

   generate
      for (genvar s = 0; s < 2; s++) begin : g_sec
         logic [BLK_W-1:0] ptr_r;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               ptr_r <= '0;
            else if (commit && (new_sec == 1'(s)))
               ptr_r <= new_blk;
         end
         assign ptr_w[s] = ptr_r;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         act_q <= 1'b0;
      else if (commit)
         act_q <= new_sec;
   end

   assign live_sec = act_q;
   assign live_blk = ptr_w[act_q];

   always_comb begin
      if (live_blk == BLK_W'(NB - 1)) begin
         next_sec = ~act_q;
         next_blk = '0;
      end else begin
         next_sec = act_q;
         next_blk = live_blk + 1'b1;
      end
   end
endmodule

// File: rtl/eee_erase_sched.sv
// Tracks stale blocks and picks the one erase allowed per update.
module eee_erase_sched #(
   parameter int BLK_W = 2
)(
   input  logic           clk,
   input  logic           rst_n,
   input  logic           mark_en,
   input  logic [BLK_W:0] mark_loc,
   input  logic           clr_en,
   input  logic [BLK_W:0] clr_loc,
   input  logic           src_sec,
   input  logic [BLK_W:0] dst_loc,
   output logic           cand_valid,
   output logic [BLK_W:0] cand_loc
);
   localparam int NB = 1 << BLK_W;
   localparam int NL = 2 * NB;

   logic [NL-1:0] stale_q;
   logic [NL-1:0] set_v;
   logic [NL-1:0] clr_v;

   assign set_v = mark_en ? (NL'(1) << mark_loc) : '0;
   assign clr_v = clr_en  ? (NL'(1) << clr_loc)  : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         stale_q <= '0;
      else
         stale_q <= (stale_q | set_v) & ~clr_v;
   end

   always_comb begin
      cand_valid = 1'b0;
      cand_loc   = dst_loc;
      if (stale_q[dst_loc]) begin
         cand_valid = 1'b1;
      end else begin
         for (int b = NB - 1; b >= 0; b--) begin
            if (stale_q[{~src_sec, BLK_W'(b)}]) begin
               cand_valid = 1'b1;
               cand_loc   = {~src_sec, BLK_W'(b)};
            end
         end
      end
   end
endmodule

// File: rtl/eee_merge.sv
// Overlays the pending page bytes onto one flash word of the copy stream.
module eee_merge #(
   parameter int ADDR_W = 10,
   parameter int PAGE_W = 4,
   parameter int WORD_W = 2
)(
   input  logic [(8<<WORD_W)-1:0]   raw,
   input  logic [ADDR_W-WORD_W-1:0] widx,
   input  logic [ADDR_W-PAGE_W-1:0] pg_idx,
   input  logic [(8<<PAGE_W)-1:0]   pg_data,
   input  logic [(1<<PAGE_W)-1:0]   pg_mask,
   output logic [(8<<WORD_W)-1:0]   merged
);
   localparam int WBY   = 1 << WORD_W;
   localparam int PGW_W = PAGE_W - WORD_W;
   localparam int WPB_W = ADDR_W - WORD_W;

   logic hit;
   assign hit = (widx[WPB_W-1:PGW_W] == pg_idx);

   generate
      for (genvar l = 0; l < WBY; l++) begin : g_lane
         always_comb begin
            int pos;
            pos = int'(widx[PGW_W-1:0]) * WBY + l;
            if (hit && pg_mask[pos])
               merged[8*l +: 8] = pg_data[8*pos +: 8];
            else
               merged[8*l +: 8] = raw[8*l +: 8];
         end
      end
   endgenerate
endmodule

// File: rtl/eee_ctrl.sv
module eee_ctrl
   import eee_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int PAGE_W = 4,
   parameter int BLK_W  = 2,
   parameter int WORD_W = 2
)(
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          hr_en,
   input  logic [ADDR_W-1:0]             hr_addr,
   output logic                          hr_valid,
   output logic [7:0]                    hr_data,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [PAGE_W:0]               wr_len,
   input  logic [(8<<PAGE_W)-1:0]        wr_data,
   output logic                          busy,
   output logic                          done,
   output logic                          err,
   output logic                          fl_rd_en,
   output logic [BLK_W+ADDR_W-WORD_W:0]  fl_rd_addr,
   input  logic [(8<<WORD_W)-1:0]        fl_rd_data,
   output logic                          fl_pg_en,
   output logic [BLK_W+ADDR_W-WORD_W:0]  fl_pg_addr,
   output logic [(8<<WORD_W)-1:0]        fl_pg_data,
   output logic                          fl_er_en,
   output logic [BLK_W:0]                fl_er_blk,
   input  logic [1:0]                    fl_busy
);
   localparam int PB    = 1 << PAGE_W;
   localparam int WB    = 8 << WORD_W;
   localparam int WPB_W = ADDR_W - WORD_W;
   localparam int LOC_W = BLK_W + 1;
   localparam int PGI_W = ADDR_W - PAGE_W;
   localparam int SUM_W = PAGE_W + 2;

   generate
      if (PAGE_W <= WORD_W || PAGE_W >= ADDR_W || BLK_W < 1 || WORD_W < 0) begin : g_bad_cfg
         $error("eee_ctrl: need WORD_W < PAGE_W < ADDR_W and BLK_W >= 1");
      end
   endgenerate

   ee_state_e        state_q;
   logic [PGI_W-1:0] pg_idx_q;
   logic [PB-1:0]    pg_mask_q;
   logic [8*PB-1:0]  pg_data_q;
   logic [LOC_W-1:0] src_q, dst_q;
   logic [WPB_W-1:0] wcnt_q;
   logic [WB-1:0]    word_q;
   logic             done_q, err_q, hv_q;
   logic [WORD_W-1:0] lane_q;

   logic             live_sec, next_sec;
   logic [BLK_W-1:0] live_blk, next_blk;
   logic             cand_valid;
   logic [LOC_W-1:0] cand_loc;
   logic [WB-1:0]    merged;

   // ---- write request qualification
   logic [PAGE_W-1:0] off;
   logic [SUM_W-1:0]  end_pos;
   logic              len_ok, accept, reject;
   logic [PB-1:0]     mask_c;
   logic [8*PB-1:0]   data_c;

   assign off     = wr_addr[PAGE_W-1:0];
   assign end_pos = SUM_W'(off) + SUM_W'(wr_len);
   assign len_ok  = (wr_len != '0) && (end_pos <= SUM_W'(PB));
   assign accept  = wr_en && (state_q == EE_IDLE) && len_ok;
   assign reject  = wr_en && !accept;
   assign data_c  = wr_data << {off, 3'b000};

   always_comb begin
      for (int b = 0; b < PB; b++)
         mask_c[b] = (SUM_W'(b) >= SUM_W'(off)) && (SUM_W'(b) < end_pos);
   end

   // ---- step conditions
   logic dst_sec, cand_sec, ones, last_w;
   logic er_go, fetch_go, pg_go, adv, commit;

   assign dst_sec  = dst_q[LOC_W-1];
   assign cand_sec = cand_loc[LOC_W-1];
   assign ones     = &word_q;
   assign last_w   = &wcnt_q;
   assign er_go    = (state_q == EE_ERASE) && cand_valid && !fl_busy[cand_sec];
   assign fetch_go = (state_q == EE_FETCH) && !hr_en;
   assign pg_go    = (state_q == EE_PROG) && !ones && !fl_busy[dst_sec];
   assign adv      = (state_q == EE_PROG) && (ones || !fl_busy[dst_sec]);
   assign commit   = (state_q == EE_COMMIT) && !fl_busy[dst_sec];

   eee_ptr_bank #(.BLK_W(BLK_W)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .commit   (commit),
      .new_sec  (dst_q[LOC_W-1]),
      .new_blk  (dst_q[BLK_W-1:0]),
      .live_sec (live_sec),
      .live_blk (live_blk),
      .next_sec (next_sec),
      .next_blk (next_blk)
   );

   eee_erase_sched #(.BLK_W(BLK_W)) u_ers (
      .clk        (clk),
      .rst_n      (rst_n),
      .mark_en    (commit),
      .mark_loc   (src_q),
      .clr_en     (er_go),
      .clr_loc    (cand_loc),
      .src_sec    (src_q[LOC_W-1]),
      .dst_loc    (dst_q),
      .cand_valid (cand_valid),
      .cand_loc   (cand_loc)
   );

   eee_merge #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .WORD_W(WORD_W)) u_mrg (
      .raw     (fl_rd_data),
      .widx    (wcnt_q),
      .pg_idx  (pg_idx_q),
      .pg_data (pg_data_q),
      .pg_mask (pg_mask_q),
      .merged  (merged)
   );

   // ---- sequencer
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= EE_IDLE;
         pg_idx_q  <= '0;
         pg_mask_q <= '0;
         pg_data_q <= '0;
         src_q     <= '0;
         dst_q     <= '0;
         wcnt_q    <= '0;
         word_q    <= '0;
         done_q    <= 1'b0;
         err_q     <= 1'b0;
         hv_q      <= 1'b0;
         lane_q    <= '0;
      end else begin
         done_q <= commit;
         err_q  <= reject;
         hv_q   <= hr_en;
         if (hr_en)
            lane_q <= hr_addr[WORD_W-1:0];
         unique case (state_q)
            EE_IDLE: if (accept) begin
               pg_idx_q  <= wr_addr[ADDR_W-1:PAGE_W];
               pg_mask_q <= mask_c;
               pg_data_q <= data_c;
               src_q     <= {live_sec, live_blk};
               dst_q     <= {next_sec, next_blk};
               wcnt_q    <= '0;
               state_q   <= EE_ERASE;
            end
            EE_ERASE: if (!cand_valid || er_go) state_q <= EE_FETCH;
            EE_FETCH: if (fetch_go) state_q <= EE_MERGE;
            EE_MERGE: begin
               word_q  <= merged;
               state_q <= EE_PROG;
            end
            EE_PROG: if (adv) begin
               if (last_w) begin
                  state_q <= EE_COMMIT;
               end else begin
                  wcnt_q  <= wcnt_q + 1'b1;
                  state_q <= EE_FETCH;
               end
            end
            EE_COMMIT: if (commit) state_q <= EE_IDLE;
            default: state_q <= EE_IDLE;
         endcase
      end
   end

   // ---- ports
   assign fl_rd_en   = hr_en || fetch_go;
   assign fl_rd_addr = hr_en ? {live_sec, live_blk, hr_addr[ADDR_W-1:WORD_W]}
                             : {src_q, wcnt_q};
   assign fl_pg_en   = pg_go;
   assign fl_pg_addr = {dst_q, wcnt_q};
   assign fl_pg_data = word_q;
   assign fl_er_en   = er_go;
   assign fl_er_blk  = cand_loc;
   assign busy       = (state_q != EE_IDLE);
   assign done       = done_q;
   assign err        = err_q;
   assign hr_valid   = hv_q;
   assign hr_data    = fl_rd_data[{lane_q, 3'b000} +: 8];
endmodule

// File: rtl/eee_ctrl_chk.sv
module eee_ctrl_chk #(
   parameter int BLK_W  = 2,
   parameter int WORD_W = 2
)(
   input logic                  clk,
   input logic                  rst_n,
   input logic                  hr_en,
   input logic                  hr_valid,
   input logic                  wr_en,
   input logic                  busy,
   input logic                  done,
   input logic                  err,
   input logic                  fl_pg_en,
   input logic [BLK_W:0]        pg_loc,
   input logic [(8<<WORD_W)-1:0] fl_pg_data,
   input logic                  fl_er_en,
   input logic [BLK_W:0]        fl_er_blk,
   input logic [1:0]            fl_busy,
   input logic                  live_sec,
   input logic [BLK_W-1:0]      live_blk
);
   p_read_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
      hr_en |=> hr_valid);

   p_busy_reject_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> err);

   p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   p_no_erased_pg_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fl_pg_en |-> (fl_pg_data != '1));

   p_pg_idle_sec_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fl_pg_en |-> !fl_busy[pg_loc[BLK_W]]);

   p_pg_not_live_r8: assert property (@(posedge clk) disable iff (!rst_n)
      fl_pg_en |-> (pg_loc != {live_sec, live_blk}));

   p_er_not_live_r9: assert property (@(posedge clk) disable iff (!rst_n)
      fl_er_en |-> (fl_er_blk != {live_sec, live_blk}));

   p_er_pg_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_er_en && fl_pg_en));
endmodule

bind eee_ctrl eee_ctrl_chk #(.BLK_W(BLK_W), .WORD_W(WORD_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .hr_en      (hr_en),
   .hr_valid   (hr_valid),
   .wr_en      (wr_en),
   .busy       (busy),
   .done       (done),
   .err        (err),
   .fl_pg_en   (fl_pg_en),
   .pg_loc     (fl_pg_addr[BLK_W+ADDR_W-WORD_W -: BLK_W+1]),
   .fl_pg_data (fl_pg_data),
   .fl_er_en   (fl_er_en),
   .fl_er_blk  (fl_er_blk),
   .fl_busy    (fl_busy),
   .live_sec   (live_sec),
   .live_blk   (live_blk)
);

// File: tb/eee_ctrl_test.sv
module eee_ctrl_test;
   localparam int PG_LAT = 3;
   localparam int ER_LAT = 150;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         hr_en = 1'b0;
   logic [9:0]   hr_addr = '0;
   logic         hr_valid;
   logic [7:0]   hr_data;
   logic         wr_en = 1'b0;
   logic [9:0]   wr_addr = '0;
   logic [4:0]   wr_len = '0;
   logic [127:0] wr_data = '0;
   logic         busy, done, err;
   logic         fl_rd_en, fl_pg_en, fl_er_en;
   logic [10:0]  fl_rd_addr, fl_pg_addr;
   logic [31:0]  fl_rd_data, fl_pg_data;
   logic [2:0]   fl_er_blk;
   logic [1:0]   fl_busy;

   always #5 clk = ~clk;

   eee_ctrl uut (
      .clk(clk), .rst_n(rst_n),
      .hr_en(hr_en), .hr_addr(hr_addr), .hr_valid(hr_valid), .hr_data(hr_data),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_len(wr_len), .wr_data(wr_data),
      .busy(busy), .done(done), .err(err),
      .fl_rd_en(fl_rd_en), .fl_rd_addr(fl_rd_addr), .fl_rd_data(fl_rd_data),
      .fl_pg_en(fl_pg_en), .fl_pg_addr(fl_pg_addr), .fl_pg_data(fl_pg_data),
      .fl_er_en(fl_er_en), .fl_er_blk(fl_er_blk), .fl_busy(fl_busy)
   );

   // ---- flash model: programming ANDs bits in, erase sets a block to ones
   logic [31:0] fmem [0:2047];
   int bcnt [2];
   int n_ones = 0, n_pg_busy = 0, n_er = 0, n_er_live = 0;
   int exp_sec = 0, exp_blk = 0;

   assign fl_busy = {bcnt[1] != 0, bcnt[0] != 0};

   initial begin
      for (int i = 0; i < 2048; i++) fmem[i] = '1;
      bcnt[0] = 0;
      bcnt[1] = 0;
   end

   always @(posedge clk) begin
      if (fl_rd_en) fl_rd_data <= fmem[fl_rd_addr];
      for (int s = 0; s < 2; s++) begin
         if (fl_pg_en && fl_pg_addr[10] == 1'(s))      bcnt[s] <= PG_LAT;
         else if (fl_er_en && fl_er_blk[2] == 1'(s))   bcnt[s] <= ER_LAT;
         else if (bcnt[s] != 0)                        bcnt[s] <= bcnt[s] - 1;
      end
      if (fl_pg_en) begin
         fmem[fl_pg_addr] <= fmem[fl_pg_addr] & fl_pg_data;
         if (fl_pg_data == '1) n_ones <= n_ones + 1;
         if (bcnt[fl_pg_addr[10]] != 0) n_pg_busy <= n_pg_busy + 1;
      end
      if (fl_er_en) begin
         n_er <= n_er + 1;
         if (fl_er_blk == 3'({exp_sec[0], exp_blk[1:0]})) n_er_live <= n_er_live + 1;
         for (int i = 0; i < 256; i++) fmem[{fl_er_blk, 8'(i)}] <= '1;
      end
   end

   // ---- reference image and reporting
   logic [7:0] refm [0:1023];
   int n_chk = 0, n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint expv);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, expv);
      end
   endtask

   function automatic void ref_apply(input int a, input int len, input logic [127:0] d);
      for (int j = 0; j < len; j++) refm[a + j] = d[8*j +: 8];
   endfunction

   task automatic host_read(input int a, output logic [7:0] d, output logic [10:0] fa);
      @(negedge clk);
      hr_en = 1'b1;
      hr_addr = 10'(a);
      #1 fa = fl_rd_addr;
      @(negedge clk);
      hr_en = 1'b0;
      d = hr_data;
      chk(hr_valid == 1'b1, "R2", "hr_valid after read", longint'(hr_valid), 1);
   endtask

   task automatic read_cmp(input int a, input string req);
      logic [7:0] d;
      logic [10:0] fa;
      host_read(a, d, fa);
      chk(d == refm[a], req, $sformatf("byte %0h", a), d, refm[a]);
   endtask

   task automatic issue_write(input int a, input int len, input logic [127:0] d, input bit exp_err);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 10'(a); wr_len = 5'(len); wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
      chk(err == exp_err, exp_err ? "R4" : "R3", "err pulse", longint'(err), longint'(exp_err));
   endtask

   task automatic wait_done(input int er_before);
      int n;
      n = 0;
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
      end
      chk(done == 1'b1 && busy == 1'b0, "R7", "done with busy low", {busy, done}, 2'b01);
      chk((n_er - er_before) <= 1, "R9", "erases per update", n_er - er_before, 1);
      if (exp_blk == 3) begin exp_blk = 0; exp_sec = 1 - exp_sec; end
      else exp_blk++;
      @(negedge clk);
      chk(done == 1'b0, "R7", "done one cycle", longint'(done), 0);
   endtask

   task automatic check_loc();
      logic [7:0] d;
      logic [10:0] fa;
      host_read(0, d, fa);
      chk(fa[10:8] == 3'({exp_sec[0], exp_blk[1:0]}), "R5", "live block", fa[10:8],
          {exp_sec[0], exp_blk[1:0]});
   endtask

   task automatic good_write(input int a, input int len, input logic [127:0] d);
      int e0;
      e0 = n_er;
      issue_write(a, len, d, 1'b0);
      chk(busy == 1'b1, "R3", "busy after accept", longint'(busy), 1);
      wait_done(e0);
      ref_apply(a, len, d);
      check_loc();
   endtask

   // ---- watchdog
   initial begin
      repeat (190000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   // ---- main sequence
   initial begin
      logic [7:0]   d;
      logic [10:0]  fa;
      logic [127:0] rd;
      void'($urandom(32'd20240611));
      for (int i = 0; i < 1024; i++) refm[i] = 8'hFF;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state and address mapping
      chk(busy == 0 && done == 0 && err == 0, "R1", "reset outputs", {busy, done, err}, 0);
      host_read(10'h2C7, d, fa);
      chk(fa == 11'h0B1, "R1", "translated address", fa, 11'h0B1);
      chk(d == 8'hFF, "R2", "erased byte", d, 8'hFF);

      // R3 full page, first-offset run, last-offset byte
      good_write(10'h000, 16, 128'h0F0E0D0C0B0A09080706050403020100);
      read_cmp(10'h000, "R3");
      read_cmp(10'h00F, "R3");
      good_write(10'h3F5, 3, 128'h00000000000000000000000000C3B2A1);
      read_cmp(10'h3F5, "R3");
      read_cmp(10'h3F7, "R3");
      read_cmp(10'h3F4, "R3");
      read_cmp(10'h3F8, "R3");
      good_write(10'h3FF, 1, 128'h77);
      read_cmp(10'h3FF, "R3");

      // R4 zero length and page overrun
      issue_write(10'h100, 0, '1, 1'b1);
      chk(busy == 1'b0, "R4", "busy after zero length", longint'(busy), 0);
      issue_write(10'h20A, 8, 128'h1111111111111111, 1'b1);
      chk(busy == 1'b0, "R4", "busy after overrun", longint'(busy), 0);
      read_cmp(10'h20A, "R4");

      // R6 reads during an update; R4 write while busy
      begin
         int e0;
         e0 = n_er;
         issue_write(10'h123, 4, 128'hC33C5AA5, 1'b0);
         host_read(10'h123, d, fa);
         chk(d == refm[10'h123], "R6", "old byte during update", d, refm[10'h123]);
         chk(fa[10:8] == 3'({exp_sec[0], exp_blk[1:0]}), "R6", "old block during update",
             fa[10:8], {exp_sec[0], exp_blk[1:0]});
         issue_write(10'h300, 2, 128'hBEEF, 1'b1);
         wait_done(e0);
         ref_apply(10'h123, 4, 128'hC33C5AA5);
         read_cmp(10'h123, "R6");
         read_cmp(10'h126, "R6");
         read_cmp(10'h300, "R4");
         check_loc();
      end

      // random page writes across several sector wraps
      for (int k = 0; k < 24; k++) begin
         int pg, off, len;
         pg  = $urandom_range(63);
         off = $urandom_range(15);
         len = $urandom_range(16 - off, 1);
         rd  = {$urandom, $urandom, $urandom, $urandom};
         good_write(pg * 16 + off, len, rd);
         read_cmp(pg * 16 + off, "R3");
         read_cmp($urandom_range(1023), "R5");
      end

      // whole-image readback: exact copy through every wrap (R8, R9)
      for (int a = 0; a < 1024; a++) begin
         host_read(a, d, fa);
         if (d != refm[a]) chk(1'b0, "R8", $sformatf("image byte %0h", a), d, refm[a]);
      end
      chk(1'b1, "R8", "image readback", 0, 0);
      chk(n_ones == 0, "R8", "all-ones programs", n_ones, 0);
      chk(n_pg_busy == 0, "R8", "program to busy sector", n_pg_busy, 0);
      chk(n_er > 0, "R9", "erases issued", n_er, 1);
      chk(n_er_live == 0, "R9", "erase of live block", n_er_live, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule